// File: doc/BRIEF.md
# Power-up Reset Sequencer

This block keeps a microcontroller core in reset after the supply comes up, until two timed stages have finished. A power-on pulse from an analog supply-rise detector starts the sequence. The first stage waits a fixed nominal delay of about 72 ms. It measures this delay by counting rising edges of a slow internal RC clock that runs independently of the main clock. A configuration input can skip this stage. The second stage counts 1024 cycles of the main oscillator clock so that a crystal or resonator can settle. It runs only when the oscillator mode selects a crystal-type source.

The whole sequencer runs on the main oscillator clock. The RC clock is brought in through a synchroniser and reduced to a one-cycle tick. An active-low master-clear input forces the core into reset at once. Its release passes through a two-stage synchroniser. A wake-from-sleep event in a crystal mode reruns only the oscillator settling stage. The supply-delay stage runs again only on a fresh power-on pulse, and such a pulse restarts the sequence from the first stage whenever it arrives. Two status flags report when each stage is complete.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `por_pulse` is high, `core_rst_n`, `pwrt_done` and `ost_done` are 0. A new pulse in any stage restarts the sequence from the first stage.
- R2: With `pwrt_en`=1, `pwrt_done` rises after the PWRT_TICKS-th rising edge of `rc_clk` following power-on release, within 4 clock cycles of that edge, and not before it.
- R3: With `pwrt_en`=0, the first stage is skipped, and `pwrt_done` is 1 after the first clock edge following power-on release.
- R4: In the crystal modes (`osc_mode` 00 low-power, 01 standard, 10 high-speed), `ost_done` rises exactly OST_CYCLES clock edges after `pwrt_done` rises, and the settling stage never runs before `pwrt_done` is set.
- R5: In RC mode (`osc_mode` 11), the settling stage is bypassed and `ost_done` rises on the same edge as `pwrt_done`.
- R6: With `mclr_n` high and synchronised, `core_rst_n` rises on the same edge as `ost_done`. It is never 1 unless both done flags are 1. After power-on release it cannot rise before the third clock edge.
- R7: A low `mclr_n` drives `core_rst_n` low at once, without a clock edge, and leaves both stages and flags running. After `mclr_n` rises, `core_rst_n` returns to 1 on the third clock edge if the sequence is complete.
- R8: A `wake_evt` sampled high after the sequence is complete, in a crystal mode, clears `ost_done` and `core_rst_n` on that edge. Both return to 1 exactly OST_CYCLES edges later.
- R9: A `wake_evt` in RC mode, or while a stage is still running, is ignored: the outputs and the stage timing are unchanged.
- R10: Once set, `pwrt_done` stays 1 until the next power-on pulse. A wake event does not rerun the first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous restart |
| mclr_n | input | 1 | External master clear, active low |
| wake_evt | input | 1 | Wake-from-sleep event, synchronous to clk |
| pwrt_en | input | 1 | Enables the supply-delay stage |
| osc_mode | input | 2 | 00 LP, 01 XT, 10 HS, 11 RC |
| rc_clk | input | 1 | Slow internal RC clock, asynchronous |
| core_rst_n | output | 1 | Core reset, active low, registered |
| pwrt_done | output | 1 | First stage complete or skipped |
| ost_done | output | 1 | Settling stage complete or bypassed |

## Verification
On every cycle, the assertions check these properties:
- The master clear holds the core in reset.
- The core is released only while both flags are set and the sequencer is in its run state.
- The supply-delay flag never drops once set.
- The settling stage never starts in RC mode and never runs ahead of the first stage.
- The settling stage lasts exactly OST_CYCLES edges.

Only the bench scenarios can show the following:
- How the first-stage delay lines up with the RC clock edge count.
- The three-edge release after the master clear and after a bare power-on.
- That a wake event in RC mode or mid-stage is ignored.
- That a fresh power-on pulse in the middle of the settling stage reruns the whole sequence.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    ST_PWRT = 2'd0,
    ST_OST  = 2'd1,
    ST_RUN  = 2'd2
  } seq_st_t;

  localparam logic [1:0] MODE_RC = 2'b11;

  // Crystal-type sources (LP, XT, HS) need the settling stage.
  function automatic logic mode_needs_ost(input logic [1:0] mode);
    return mode != MODE_RC;
  endfunction

  // RC ticks that make up the nominal supply delay.
  function automatic int pwrt_ticks(input int nom_ns, input int per_ns,
                                    input bit fast, input int sim_ticks);
    int t;
    t = fast ? sim_ticks : nom_ns / per_ns;
    return (t < 1) ? 1 : t;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pwr_tick_cnt.sv
module pwr_tick_cnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                    cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == TOP);
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import pwrup_pkg::*;
#(
  parameter int PWRT_NOM_NS  = 72_000_000,
  parameter int RC_PERIOD_NS = 18_000,
  parameter bit FAST_SIM     = 1'b0,
  parameter int SIM_TICKS    = 8,
  parameter int OST_CYCLES   = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       mclr_n,
  input  logic       wake_evt,
  input  logic       pwrt_en,
  input  logic [1:0] osc_mode,
  input  logic       rc_clk,
  output logic       core_rst_n,
  output logic       pwrt_done,
  output logic       ost_done
);
  localparam int PWRT_TICKS = pwrt_ticks(PWRT_NOM_NS, RC_PERIOD_NS, FAST_SIM, SIM_TICKS);

  seq_st_t st, nxt;
  logic rc_q, rc_d, rc_tick;
  logic mclr_q, mclr_clr;
  logic pwrt_last, ost_last;
  logic pwrt_busy, ost_busy, run_now;
  logic needs_ost, pwrt_fin, ost_fin, wake_ost, ost_start;

  // RC clock into the main domain, reduced to a one-cycle tick
  pwr_sync #(.STAGES(SYNC_STAGES)) u_rc_sync (
    .clk(clk), .clr(por_pulse), .d(rc_clk), .q(rc_q)
  );

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) rc_d <= 1'b0;
    else           rc_d <= rc_q;
  end
  assign rc_tick = rc_q & ~rc_d;

  // Master clear: asynchronous hold, synchronised release
  assign mclr_clr = por_pulse | ~mclr_n;
  pwr_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
    .clk(clk), .clr(mclr_clr), .d(1'b1), .q(mclr_q)
  );

  assign pwrt_busy = (st == ST_PWRT);
  assign ost_busy  = (st == ST_OST);
  assign run_now   = (st == ST_RUN);
  assign needs_ost = mode_needs_ost(osc_mode);

  assign pwrt_fin  = pwrt_busy && (!pwrt_en || (rc_tick && pwrt_last));
  assign ost_fin   = ost_busy && ost_last;
  assign wake_ost  = run_now && wake_evt && needs_ost;
  assign ost_start = (pwrt_fin && needs_ost) || wake_ost;

  pwr_tick_cnt #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
    .clk(clk), .rst(por_pulse), .clr(!pwrt_busy),
    .inc(pwrt_busy && rc_tick), .last(pwrt_last)
  );

  pwr_tick_cnt #(.LIMIT(OST_CYCLES)) u_ost_cnt (
    .clk(clk), .rst(por_pulse), .clr(!ost_busy),
    .inc(ost_busy), .last(ost_last)
  );

  always_comb begin
    nxt = st;
    if (pwrt_fin)      nxt = needs_ost ? ST_OST : ST_RUN;
    else if (ost_fin)  nxt = ST_RUN;
    else if (wake_ost) nxt = ST_OST;
  end

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) begin
      st        <= ST_PWRT;
      pwrt_done <= 1'b0;
      ost_done  <= 1'b0;
    end else begin
      st <= nxt;
      if (pwrt_fin) pwrt_done <= 1'b1;
      if (ost_start)                            ost_done <= 1'b0;
      else if (ost_fin || (pwrt_fin && !needs_ost)) ost_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or posedge mclr_clr) begin
    if (mclr_clr) core_rst_n <= 1'b0;
    else          core_rst_n <= (nxt == ST_RUN) && mclr_q;
  end
endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk #(
  parameter int OST_CYCLES = 1024
) (
  input logic       clk,
  input logic       por_pulse,
  input logic       mclr_n,
  input logic [1:0] osc_mode,
  input logic       core_rst_n,
  input logic       pwrt_done,
  input logic       ost_done,
  input logic       ost_busy,
  input logic       ost_start,
  input logic       run_now
);
  int unsigned ost_len;

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse)     ost_len <= 0;
    else if (ost_busy) ost_len <= ost_len + 1;
    else               ost_len <= 0;
  end

  AST_MCLR_HOLD: assert property (@(posedge clk) disable iff (por_pulse)
    !mclr_n |-> !core_rst_n); // R7

  AST_RELEASE_NEEDS_DONE: assert property (@(posedge clk) disable iff (por_pulse)
    core_rst_n |-> (pwrt_done && ost_done)); // R6

  AST_RELEASE_IN_RUN: assert property (@(posedge clk) disable iff (por_pulse)
    $rose(core_rst_n) |-> run_now); // R6

  AST_PWRT_STICKY: assert property (@(posedge clk) disable iff (por_pulse)
    pwrt_done |=> pwrt_done); // R10

  AST_RC_NO_OST: assert property (@(posedge clk) disable iff (por_pulse)
    ost_start |-> (osc_mode != 2'b11)); // R5

  AST_OST_AFTER_PWRT: assert property (@(posedge clk) disable iff (por_pulse)
    ost_busy |-> pwrt_done); // R4

  AST_OST_LENGTH: assert property (@(posedge clk) disable iff (por_pulse)
    ($rose(ost_done) && $past(ost_busy)) |-> (ost_len == OST_CYCLES)); // R4
endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk #(.OST_CYCLES(OST_CYCLES)) u_chk (
  .clk(clk), .por_pulse(por_pulse), .mclr_n(mclr_n), .osc_mode(osc_mode),
  .core_rst_n(core_rst_n), .pwrt_done(pwrt_done), .ost_done(ost_done),
  .ost_busy(ost_busy), .ost_start(ost_start), .run_now(run_now)
);

// File: tb/tb_pwrup_rst_seq.sv
`timescale 1ns/1ps
module tb_pwrup_rst_seq;
  localparam int TICKS = 8;
  localparam int OSTC  = 1024;

  logic clk = 1'b0, rc_clk = 1'b0, rc_run = 1'b0;
  logic por_pulse = 1'b1, mclr_n = 1'b1, wake_evt = 1'b0, pwrt_en = 1'b1;
  logic [1:0] osc_mode = 2'b01;
  logic core_rst_n, pwrt_done, ost_done;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always #20 rc_clk = rc_run ? ~rc_clk : 1'b0;
  always @(posedge clk) cyc++;

  pwrup_rst_seq #(.FAST_SIM(1'b1), .SIM_TICKS(TICKS), .OST_CYCLES(OSTC)) dut (
    .clk(clk), .por_pulse(por_pulse), .mclr_n(mclr_n), .wake_evt(wake_evt),
    .pwrt_en(pwrt_en), .osc_mode(osc_mode), .rc_clk(rc_clk),
    .core_rst_n(core_rst_n), .pwrt_done(pwrt_done), .ost_done(ost_done)
  );

  function automatic int exp_gap(input logic [1:0] m);
    return (m == 2'b11) ? 0 : OSTC;
  endfunction
  function automatic int exp_core(input int k_ost);
    return (k_ost < 3) ? 3 : k_ost;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_por(input logic [1:0] m, input logic en);
    @(negedge clk);
    rc_run = 1'b0; por_pulse = 1'b1;
    repeat (12) @(negedge clk);
    chk(!core_rst_n && !pwrt_done && !ost_done, "R1 outputs low in power-on",
        {core_rst_n, pwrt_done, ost_done}, 0);
    osc_mode = m; pwrt_en = en;
    por_pulse = 1'b0; rc_run = 1'b1;
  endtask

  // Counts negedges after a start point; first index each signal is seen high.
  task automatic run_seq(output int kp, output int ko, output int kc);
    kp = -1; ko = -1; kc = -1;
    for (int k = 1; k < 4000; k++) begin
      @(negedge clk);
      if (kp < 0 && pwrt_done) kp = k;
      if (ko < 0 && ost_done) ko = k;
      if (kc < 0 && core_rst_n) kc = k;
      if (kc >= 0) break;
    end
  endtask

  task automatic pulse_wake();
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    bad++; total++;
    $display("FAIL watchdog expired cyc=%0d expected<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int kp, ko, kc, seed, k0, kx;
    logic [1:0] m;
    logic en;
    seed = $urandom(32'h1d5e);

    // R2 directed: tick counting on the RC clock
    do_por(2'b01, 1'b1);
    chk(!pwrt_done, "R1 flag low right after release", pwrt_done, 0);
    repeat (TICKS - 1) @(posedge rc_clk);
    #25;
    chk(!pwrt_done, "R2 not done before last tick", pwrt_done, 0);
    @(posedge rc_clk);
    #25;
    chk(pwrt_done, "R2 done after last tick", pwrt_done, 1);

    // Random mix of modes and enable, gaps against bench model
    for (int it = 0; it < 8; it++) begin
      m = 2'($urandom_range(0, 3));
      en = 1'($urandom_range(0, 1));
      do_por(m, en);
      run_seq(kp, ko, kc);
      if (!en) chk(kp == 1, "R3 skipped stage done on first edge", kp, 1);
      if (m == 2'b11) chk(ko - kp == 0, "R5 RC bypass gap", ko - kp, 0);
      else chk(ko - kp == exp_gap(m), "R4 settling gap", ko - kp, exp_gap(m));
      chk(kc == exp_core(ko), "R6 core release edge", kc, exp_core(ko));
    end

    // R3 and R6 corner: no delay stage, RC mode
    do_por(2'b11, 1'b0);
    run_seq(kp, ko, kc);
    chk(kp == 1 && ko == 1, "R3 both flags on first edge", ko, 1);
    chk(kc == 3, "R6 release no earlier than third edge", kc, 3);

    // R7: master clear after completion
    #1 mclr_n = 1'b0;
    #1;
    chk(!core_rst_n, "R7 immediate hold", core_rst_n, 0);
    chk(pwrt_done && ost_done, "R7 flags unaffected", {pwrt_done, ost_done}, 3);
    @(negedge clk); mclr_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!core_rst_n, "R7 still held after two edges", core_rst_n, 0);
    @(negedge clk);
    chk(core_rst_n, "R7 released on third edge", core_rst_n, 1);

    // R9: wake in RC mode ignored
    pulse_wake();
    chk(ost_done && core_rst_n, "R9 RC wake ignored", {ost_done, core_rst_n}, 3);
    repeat (5) @(negedge clk);
    chk(ost_done && core_rst_n, "R9 RC wake ignored later", {ost_done, core_rst_n}, 3);

    // R8/R10: wake in HS mode reruns only the settling stage
    do_por(2'b10, 1'b0);
    run_seq(kp, ko, kc);
    pulse_wake();
    chk(!ost_done && !core_rst_n, "R8 wake clears flag and core", {ost_done, core_rst_n}, 0);
    chk(pwrt_done, "R10 delay flag kept on wake", pwrt_done, 1);
    run_seq(kp, ko, kc);
    chk(ko == OSTC, "R8 wake settling length", ko, OSTC);
    chk(kc == OSTC, "R8 core back with flag", kc, OSTC);
    chk(kp == 1, "R10 delay flag stays set", kp, 1);

    // R9: wake during settling stage does not change its timing
    do_por(2'b00, 1'b0);
    @(negedge clk);
    repeat (100) @(negedge clk);
    pulse_wake();
    run_seq(kp, ko, kc);
    chk(ko + 102 == OSTC + 1, "R9 mid-stage wake ignored", ko + 102, OSTC + 1);

    // R7: master clear during settling stage
    do_por(2'b01, 1'b0);
    @(negedge clk);
    #1 mclr_n = 1'b0;
    k0 = cyc;
    wait (ost_done);
    @(negedge clk);
    kx = cyc - k0;
    chk(kx == OSTC, "R7 settling runs under master clear", kx, OSTC);
    chk(!core_rst_n, "R7 core held while clear low", core_rst_n, 0);
    mclr_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!core_rst_n, "R7 held two edges after release", core_rst_n, 0);
    @(negedge clk);
    chk(core_rst_n, "R7 release third edge", core_rst_n, 1);

    // R1: fresh power-on in mid-settling restarts from the first stage
    do_por(2'b01, 1'b1);
    repeat (TICKS) @(posedge rc_clk);
    repeat (300) @(negedge clk);
    do_por(2'b01, 1'b1);
    repeat (3) @(negedge clk);
    chk(!pwrt_done, "R1 restart reruns first stage", pwrt_done, 0);
    run_seq(kp, ko, kc);
    chk(kp > 4 * (TICKS - 1), "R1 restart waits for ticks", kp, 4 * TICKS);
    chk(ko - kp == OSTC, "R1 restart then settling", ko - kp, OSTC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule